// File: doc/BRIEF.md
# External interrupt request latch

This block turns one active-low external interrupt pin into a single request line for a small processor's interrupt priority logic. The pin is brought into the clock domain through a short synchronizer chain. A 1-to-0 transition of the synchronized value is detected and a pending request is latched. How that request is later released depends on a sensitivity mode. In edge mode any acknowledge drops it. In edge-and-level mode it drops only after an acknowledge has been seen and the pin is back high, and those two events may come in either order.

An acknowledge comes either from the processor's vector fetch strobe or from software writing a one to the acknowledge bit of an 8-bit control/status register. That register also holds the mode bit, a local mask bit and a read-only pending flag. The request leaves the block registered. It is gated by the local mask and by the processor's global interrupt mask, and neither mask changes the latched state. A synchronous reset clears the latch and returns the block to edge mode, even if the pin is still low.

Top module: `ext_irq_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_req` and every bit of `csr_rdata` are 0 after that edge, and the mode returns to edge-only (bit 0 = 0).
- R2: A falling pin edge sets the pending latch after the two synchronizer flops plus one detection cycle. `irq_req` and flag bit 3 of `csr_rdata` show it 4 clock edges after the pin changes. A pin that is already low when the latch is empty sets nothing.
- R3: In edge mode (bit 0 = 0), an acknowledge clears the latch whether the pin is low or high. The acknowledge is a one-cycle `vec_ack`, or a register write with bit 2 = 1. Without an acknowledge, the latch stays set after the pin returns high.
- R4: In edge-and-level mode (bit 0 = 1), the latch clears only once an acknowledge has been received and the synchronized pin is high. An acknowledge that arrives while the pin is low is remembered until the pin rises. An acknowledge that arrives after the pin is high clears the latch at once.
- R5: Reset while the pin is held low removes the request, and no request appears again until the pin goes high and then falls again.
- R6: Mask bit 1 = 1 forces `irq_req` low while flag bit 3 keeps showing the pending state. Clearing the mask presents the still-pending request again.
- R7: `cpu_imask` = 1 forces `irq_req` low without changing the pending state.
- R8: If an acknowledge and a newly detected falling edge fall in the same cycle, the latch stays set.
- R9: `csr_rdata` is registered: bit 3 = pending flag, bit 2 always reads 0, bit 1 = mask, bit 0 = mode, and all higher bits are 0. A write with `csr_we` = 1 loads the mask and mode from `csr_wdata` bits 1 and 0. The clear decision in that cycle uses the mode held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle acknowledge from the processor's vector fetch |
| cpu_imask | input | 1 | Global processor interrupt mask, 1 blocks the request |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | REG_W | Register write data |
| csr_rdata | output | REG_W | Registered register read value |
| irq_req | output | 1 | Registered request to the priority logic |

## Verification
The bench targets the two release orders in edge-and-level mode. A design that cleared on acknowledge alone would drop the request while the pin is still low. A design that forgot an early acknowledge would keep the request stuck after the pin rises. It also holds the pin low through a reset: a synchronizer that reset to the high level would invent a falling edge and re-raise the request. Directed cases also cover an acknowledge landing on the same cycle as a new edge, which a wrong priority would lose, and both masks, whose wrong handling would either leak the request or discard it. A long random run against a cycle model catches off-by-one timing through the synchronizer.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int FLAG_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  typedef enum logic {
    SENSE_EDGE       = 1'b0,
    SENSE_EDGE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_lvl,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  // Reset to the low level so a pin held low through reset is not seen as an edge.
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= pin_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[LAST];
  end

  assign pin_lvl = chain[LAST];
  assign fall    = prev_q & ~chain[LAST];
endmodule

// File: rtl/eirq_core.sv
module eirq_core
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   fall,
  input  logic   pin_lvl,
  input  logic   ack,
  input  sense_e mode,
  output logic   pend
);
  logic ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      ack_seen <= 1'b0;
    end else if (fall) begin
      pend     <= 1'b1;
      ack_seen <= 1'b0;
    end else if (pend) begin
      if (mode == SENSE_EDGE) begin
        if (ack) pend <= 1'b0;
      end else if ((ack || ack_seen) && pin_lvl) begin
        pend     <= 1'b0;
        ack_seen <= 1'b0;
      end else if (ack) begin
        ack_seen <= 1'b1;
      end
    end
  end

  // R2 R8
  fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend);

  // R3
  clear_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pend)) |-> $past(ack || ack_seen));

  // R4
  level_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pend) && $past(mode == SENSE_EDGE_LEVEL)) |-> $past(pin_lvl));
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             pend,
  output sense_e           mode,
  output logic             mask,
  output logic             sw_ack,
  output logic [REG_W-1:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[REG_W-1:FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= SENSE_EDGE;
      mask <= 1'b0;
    end else if (we) begin
      mode <= sense_e'(wdata[MODE_BIT]);
      mask <= wdata[MASK_BIT];
    end
  end

  assign sw_ack = we & wdata[ACK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata           <= '0;
      rdata[FLAG_BIT] <= pend;
      rdata[MASK_BIT] <= mask;
      rdata[MODE_BIT] <= mode;
    end
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import eirq_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_n,
  input  logic             vec_ack,
  input  logic             cpu_imask,
  input  logic             csr_we,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  output logic             irq_req
);
  logic   pin_lvl, fall, pend, mask, sw_ack;
  sense_e mode;

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(pin_n), .pin_lvl(pin_lvl), .fall(fall)
  );

  eirq_core u_core (
    .clk(clk), .rst(rst), .fall(fall), .pin_lvl(pin_lvl),
    .ack(vec_ack | sw_ack), .mode(mode), .pend(pend)
  );

  eirq_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(csr_we), .wdata(csr_wdata), .pend(pend),
    .mode(mode), .mask(mask), .sw_ack(sw_ack), .rdata(csr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= pend & ~mask & ~cpu_imask;
  end

  // R6
  req_vs_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (csr_rdata[FLAG_BIT] && !csr_rdata[MASK_BIT]));
endmodule

// File: tb/ext_irq_latch_bench.sv
module ext_irq_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1, pin_n = 1'b1, vec_ack = 1'b0, cpu_imask = 1'b0, csr_we = 1'b0;
  logic [W-1:0] csr_wdata = '0;
  logic [W-1:0] csr_rdata;
  logic irq_req;
  int n_chk = 0, n_bad = 0;
  bit done = 0, started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_latch u_ext_irq_latch (
    .clk(clk), .rst(rst), .pin_n(pin_n), .vec_ack(vec_ack), .cpu_imask(cpu_imask),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_req(irq_req)
  );

  // Cycle model built from the requirements
  logic m_meta, m_sync, m_prev, m_pend, m_seen, m_mode, m_mask, m_irq;
  logic [W-1:0] m_rd;

  function automatic logic [W-1:0] status(input logic p, k, md);
    return {{(W-4){1'b0}}, p, 1'b0, k, md};
  endfunction

  always @(posedge clk) begin
    logic f, a;
    started <= 1'b1;
    if (rst) begin
      {m_meta, m_sync, m_prev, m_pend, m_seen, m_mode, m_mask, m_irq} = '0;
      m_rd = '0;
    end else begin
      f = m_prev & ~m_sync;
      a = vec_ack | (csr_we & csr_wdata[2]);
      m_rd  = status(m_pend, m_mask, m_mode);
      m_irq = m_pend & ~m_mask & ~cpu_imask;
      if (f) begin m_pend = 1; m_seen = 0; end
      else if (m_pend) begin
        if (!m_mode) begin if (a) m_pend = 0; end
        else if ((a || m_seen) && m_sync) begin m_pend = 0; m_seen = 0; end
        else if (a) m_seen = 1;
      end
      if (csr_we) begin m_mode = csr_wdata[0]; m_mask = csr_wdata[1]; end
      m_prev = m_sync; m_sync = m_meta; m_meta = pin_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R7 model irq_req", irq_req, m_irq);
    chk("R9 model csr_rdata", csr_rdata, m_rd);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] d);
    csr_we = 1; csr_wdata = d; step(1); csr_we = 0; csr_wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1; step(3); rst = 0; step(1);
  endtask

  task automatic scenario(input logic md, input bit ack_first);
    do_reset();
    chk("R1 reset irq", irq_req, 0);
    chk("R1 reset rdata", csr_rdata, 0);
    wr({7'b0, md});
    pin_n = 1; step(4);
    pin_n = 0; step(4);
    chk("R2 latch irq", irq_req, 1);
    chk("R2 R9 flag", csr_rdata, status(1, 0, md));
    if (ack_first) begin
      vec_ack = 1; step(1); vec_ack = 0; step(3);
      chk(md ? "R4 held while low" : "R3 ack clears low", irq_req, md ? 1 : 0);
      pin_n = 1; step(5);
      chk(md ? "R4 release after ack" : "R3 stays clear", irq_req, 0);
    end else begin
      pin_n = 1; step(5);
      chk(md ? "R4 pending until ack" : "R3 latched after rise", irq_req, 1);
      wr({5'b0, 1'b1, 1'b0, md}); step(3);
      chk(md ? "R4 ack after rise" : "R3 software ack", irq_req, 0);
    end
    // reset while low
    pin_n = 0; step(5);
    chk("R5 set before reset", irq_req, 1);
    do_reset(); step(6);
    chk("R5 gone after reset", irq_req, 0);
    chk("R5 mode cleared", csr_rdata, 0);
    pin_n = 1; step(4); pin_n = 0; step(4);
    chk("R5 new edge", irq_req, 1);
    pin_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    step(4);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 2; o++) scenario(m[0], o != 0);

    // masks
    do_reset(); pin_n = 1; step(4); pin_n = 0; step(4);
    wr(8'h02); step(2);
    chk("R6 masked irq", irq_req, 0);
    chk("R6 flag kept", csr_rdata, status(1, 1, 0));
    wr(8'h00); step(2);
    chk("R6 unmasked", irq_req, 1);
    cpu_imask = 1; step(2);
    chk("R7 cpu mask", irq_req, 0);
    cpu_imask = 0; step(2);
    chk("R7 cpu unmask", irq_req, 1);

    // edge and ack in the same cycle
    pin_n = 1; step(4);
    chk("R8 pre", irq_req, 1);
    pin_n = 0; step(2); vec_ack = 1; step(1); vec_ack = 0; step(3);
    chk("R8 edge beats ack", irq_req, 1);

    // register format
    wr(8'h04); step(2); pin_n = 1;
    wr(8'hFB); step(1);
    chk("R9 readback", csr_rdata, 8'h03);
    wr(8'h00); step(1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) pin_n = ~pin_n;
      vec_ack   = ($urandom_range(0, 15) == 0);
      cpu_imask = ($urandom_range(0, 9) == 0);
      csr_we    = ($urandom_range(0, 19) == 0);
      csr_wdata = W'($urandom_range(0, 255));
      step(1);
    end
    vec_ack = 0; cpu_imask = 0; csr_we = 0;
    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule